// File: doc/BRIEF.md
# Circuit Path Setup Switch

This block is one switch node of a circuit-switched on-chip mesh. It has five input ports and five output ports: port 0 faces the local endpoint, and ports 1 to 4 face the east, west, north and south neighbours. An input and an output with the same index lead to the same neighbour. Before any payload moves, a probe token carries the destination coordinates. The node works out the output for the probe by dimension-ordered routing, arbitrates for that output and reserves it, then forwards the probe.

The neighbour replies with an acknowledgment token. It arrives on the input whose index equals the reserved output. The node sends it upstream on the output whose index equals the probe's input, and locks the crossbar connection at that moment. From then on, data tokens on the locked input go straight to the locked output, with no routing and no arbitration step. Setup cost is therefore paid once per message. A release token follows the same path forward and tears the connection down.

Each port has valid, ready, a 2-bit token type and a data word. The node holds at most one token per output.

Top module: `cs_path_switch`

## Requirements
- R1: After a synchronous reset, all `out_valid` bits and `err_drop` are low.
- R2: Token types are 2'b00 probe, 2'b01 ack, 2'b10 data and 2'b11 release. A probe holds the destination X in data bits [COORD_W-1:0] and the destination Y in bits [2*COORD_W-1:COORD_W]. It is routed as follows:
  - destination X greater than the node's X: port 1
  - destination X smaller than the node's X: port 2
  - X equal and Y greater: port 3
  - X equal and Y smaller: port 4
  - both equal: port 0

  An accepted probe appears on that output in the next cycle with its data unchanged.
- R3: When several inputs present probes for the same free output in the same cycle, the lowest input index is accepted and the others see ready low.
- R4: A probe whose chosen output is reserved or locked is held with ready low until that output becomes free again.
- R5: An ack on input k, while output k is reserved, is accepted and appears in the next cycle on the output whose index is the input that reserved output k. Output k then becomes locked.
- R6: A data or release token on an input with a locked connection is accepted and appears on the locked output in the next cycle with type and data unchanged.
- R7: After a release is accepted at a clock edge, the freed output stays unavailable for one more cycle. A probe waiting for it is accepted at the second edge after the release.
- R8: A token that is invalid for its input's current state is accepted and dropped, and `err_drop` goes high and stays high until reset. Such tokens are data or release without a locked connection, an ack with no matching reservation, and a probe on an input that already holds a path.
- R9: While `out_valid` is high and `out_ready` is low, that output's valid, type and data stay unchanged, and a token for it on a locked input sees ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 5 | Token present, one bit per input |
| in_ready | output | 5 | Token accepted this cycle, one bit per input |
| in_type | input | 10 | Token type, 2 bits per input |
| in_data | input | 5*DATA_W | Token data, DATA_W bits per input |
| out_valid | output | 5 | Token present, one bit per output |
| out_ready | input | 5 | Downstream accepts, one bit per output |
| out_type | output | 10 | Token type, 2 bits per output |
| out_data | output | 5*DATA_W | Token data, DATA_W bits per output |
| err_drop | output | 1 | Sticky flag for dropped tokens |

## Verification
The bench builds the node with COORD_W=2, DATA_W=8 and the node's position at (1,1) on a 4 by 4 grid. This places the node off centre, so each of the five routing results is reachable with a short destination word. The 8-bit data also leaves spare upper bits, which carry a tag and show that a routed probe keeps its payload. The same sizes make it cheap to set up and tear down circuits on every port, including the local loop from input 0 to output 0.

// File: rtl/cs_path_switch.sv
module cs_path_switch #(
  parameter int COORD_W = 2,
  parameter int DATA_W  = 8,
  parameter int MY_X    = 1,
  parameter int MY_Y    = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [4:0]           in_valid,
  output logic [4:0]           in_ready,
  input  logic [9:0]           in_type,
  input  logic [5*DATA_W-1:0]  in_data,
  output logic [4:0]           out_valid,
  input  logic [4:0]           out_ready,
  output logic [9:0]           out_type,
  output logic [5*DATA_W-1:0]  out_data,
  output logic                 err_drop
);
  localparam int NP = 5;
  localparam int PW = 3;
  localparam logic [COORD_W-1:0] MX = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] MY = COORD_W'(MY_Y);
  localparam logic [1:0] T_PRB = 2'b00, T_ACK = 2'b01, T_DAT = 2'b10, T_REL = 2'b11;

  typedef enum logic [1:0] {S_FREE, S_RESV, S_LOCK, S_DRAIN} ost_t;

  ost_t              st  [NP];
  logic [PW-1:0]     own [NP];
  logic [NP-1:0]     ov;
  logic [1:0]        oty [NP];
  logic [DATA_W-1:0] od  [NP];
  logic              err;

  logic [1:0]        ity [NP];
  logic [DATA_W-1:0] idat [NP];
  logic [PW-1:0]     rt [NP], dst [NP], asrc [NP], gi [NP], fi [NP];
  logic [NP-1:0]     busy, lck, ackr, ackn, fwdr, prbr, ldok, gv, fv;
  logic [NP-1:0]     pgo, fgo, ago, drop, ld, relgo;
  logic [1:0]        lty [NP];
  logic [DATA_W-1:0] ldd [NP];

  function automatic logic [PW-1:0] route(input logic [DATA_W-1:0] d);
    logic [COORD_W-1:0] dx, dy;
    dx = d[COORD_W-1:0];
    dy = d[2*COORD_W-1:COORD_W];
    if (dx > MX)      return 3'd1;
    else if (dx < MX) return 3'd2;
    else if (dy > MY) return 3'd3;
    else if (dy < MY) return 3'd4;
    else              return 3'd0;
  endfunction

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      ity[i]  = in_type[2*i +: 2];
      idat[i] = in_data[DATA_W*i +: DATA_W];
      rt[i]   = route(idat[i]);
      busy[i] = 1'b0;
      lck[i]  = 1'b0;
      dst[i]  = '0;
      for (int o = 0; o < NP; o++) begin
        if (st[o] != S_FREE && own[o] == PW'(i)) busy[i] = 1'b1;
        if (st[o] == S_LOCK && own[o] == PW'(i)) begin
          lck[i] = 1'b1;
          dst[i] = PW'(o);
        end
      end
    end
    for (int o = 0; o < NP; o++) ldok[o] = !ov[o] || out_ready[o];
    for (int i = 0; i < NP; i++) begin
      ackr[i] = in_valid[i] && ity[i] == T_ACK && st[i] == S_RESV;
      fwdr[i] = in_valid[i] && (ity[i] == T_DAT || ity[i] == T_REL) && lck[i];
      prbr[i] = in_valid[i] && ity[i] == T_PRB && !busy[i];
    end
    for (int o = 0; o < NP; o++) begin
      ackn[o] = 1'b0; asrc[o] = '0;
      gv[o] = 1'b0;   gi[o] = '0;
      fv[o] = 1'b0;   fi[o] = '0;
      for (int k = 0; k < NP; k++)
        if (ackr[k] && own[k] == PW'(o)) begin
          ackn[o] = 1'b1;
          asrc[o] = PW'(k);
        end
      for (int i = NP-1; i >= 0; i--)
        if (prbr[i] && rt[i] == PW'(o)) begin
          gv[o] = 1'b1;
          gi[o] = PW'(i);
        end
      if (st[o] != S_FREE || !ldok[o] || ackn[o]) gv[o] = 1'b0;
      for (int i = 0; i < NP; i++)
        if (fwdr[i] && dst[i] == PW'(o)) begin
          fv[o] = 1'b1;
          fi[o] = PW'(i);
        end
      fv[o] = fv[o] && ldok[o] && !ackn[o];
      ld[o]  = 1'b0;
      lty[o] = T_PRB;
      ldd[o] = '0;
      if (ackn[o] && ldok[o]) begin
        ld[o] = 1'b1; lty[o] = T_ACK; ldd[o] = idat[asrc[o]];
      end else if (fv[o]) begin
        ld[o] = 1'b1; lty[o] = ity[fi[o]]; ldd[o] = idat[fi[o]];
      end else if (gv[o]) begin
        ld[o] = 1'b1; lty[o] = T_PRB; ldd[o] = idat[gi[o]];
      end
      relgo[o] = fv[o] && ity[fi[o]] == T_REL;
    end
    for (int i = 0; i < NP; i++) begin
      pgo[i]  = prbr[i] && gv[rt[i]] && gi[rt[i]] == PW'(i);
      fgo[i]  = fwdr[i] && fv[dst[i]];
      ago[i]  = ackr[i] && ldok[own[i]];
      drop[i] = in_valid[i] && !prbr[i] && !ackr[i] && !fwdr[i];
    end
  end

  assign in_ready  = pgo | fgo | ago | drop;
  assign out_valid = ov;
  assign err_drop  = err;

  always_comb
    for (int o = 0; o < NP; o++) begin
      out_type[2*o +: 2]          = oty[o];
      out_data[DATA_W*o +: DATA_W] = od[o];
    end

  always_ff @(posedge clk) begin
    if (rst) begin
      ov  <= '0;
      err <= 1'b0;
      for (int o = 0; o < NP; o++) begin
        st[o]  <= S_FREE;
        own[o] <= '0;
        oty[o] <= T_PRB;
        od[o]  <= '0;
      end
    end else begin
      err <= err | (|drop);
      for (int o = 0; o < NP; o++) begin
        if (ld[o]) begin
          ov[o]  <= 1'b1;
          oty[o] <= lty[o];
          od[o]  <= ldd[o];
        end else if (out_ready[o]) ov[o] <= 1'b0;
        case (st[o])
          S_FREE:  if (gv[o]) begin st[o] <= S_RESV; own[o] <= gi[o]; end
          S_RESV:  if (ago[o]) st[o] <= S_LOCK;
          S_LOCK:  if (relgo[o]) st[o] <= S_DRAIN;
          default: st[o] <= S_FREE;
        endcase
      end
    end
  end

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $past(err_drop) |-> err_drop);

  for (genvar g = 0; g < NP; g++) begin : g_chk
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
      out_valid[g] && !out_ready[g] |=> out_valid[g] && $stable(out_type[2*g +: 2])
                                        && $stable(out_data[DATA_W*g +: DATA_W]));
    assert_lock_R5: assert property (@(posedge clk) disable iff (rst)
      st[g] == S_LOCK && $past(st[g] == S_RESV)
        |-> $past(in_valid[g] && in_type[2*g +: 2] == T_ACK && in_ready[g]));
    assert_free_R7: assert property (@(posedge clk) disable iff (rst)
      st[g] == S_DRAIN |-> out_valid[g] && out_type[2*g +: 2] == T_REL);
  end
endmodule

// File: tb/sim_cs_path_switch.sv
`timescale 1ns/1ps
module sim_cs_path_switch;
  localparam int DW = 8;
  localparam logic [1:0] PRB = 2'b00, ACK = 2'b01, DAT = 2'b10, REL = 2'b11;

  logic          clk = 1'b0, rst = 1'b1;
  logic [4:0]    in_valid = '0, in_ready, out_valid, out_ready = '1;
  logic [9:0]    in_type = '0, out_type;
  logic [5*DW-1:0] in_data = '0, out_data;
  logic          err_drop;

  int total = 0, bad = 0;
  int cnt [5];
  logic [1:0]    cty [5];
  logic [DW-1:0] cdat [5];

  cs_path_switch #(.COORD_W(2), .DATA_W(DW), .MY_X(1), .MY_Y(1)) u0 (
    .clk, .rst, .in_valid, .in_ready, .in_type, .in_data,
    .out_valid, .out_ready, .out_type, .out_data, .err_drop);

  always #2.5 clk = ~clk;

  initial for (int o = 0; o < 5; o++) begin cnt[o] = 0; cty[o] = '0; cdat[o] = '0; end

  always @(negedge clk)
    for (int o = 0; o < 5; o++)
      if (out_valid[o] && out_ready[o]) begin
        cnt[o]  = cnt[o] + 1;
        cty[o]  = out_type[2*o +: 2];
        cdat[o] = out_data[DW*o +: DW];
      end

  // {data, expected output port}
  localparam logic [10:0] VEC [6] = '{
    {8'h15, 3'd0}, {8'h2B, 3'd1}, {8'h3C, 3'd2},
    {8'h4D, 3'd3}, {8'h51, 3'd4}, {8'h66, 3'd1}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic drive(input int i, input logic [1:0] t, input logic [DW-1:0] d);
    in_valid[i] = 1'b1;
    in_type[2*i +: 2] = t;
    in_data[DW*i +: DW] = d;
  endtask

  task automatic send(input int i, input logic [1:0] t, input logic [DW-1:0] d);
    bit ok;
    @(negedge clk);
    drive(i, t, d);
    ok = 0;
    for (int n = 0; n < 6 && !ok; n++) begin
      #1 ok = in_ready[i];
      @(negedge clk);
    end
    in_valid[i] = 1'b0;
  endtask

  task automatic check_out(input int o, input int c0, input logic [1:0] t,
                           input logic [DW-1:0] d, input string req);
    @(negedge clk); #1;
    chk(cnt[o] == c0 + 1, req, cnt[o] - c0, 1);
    chk(cty[o] == t && cdat[o] == d, req, {cty[o], cdat[o]}, {t, d});
  endtask

  task automatic lock_0_to_1;
    int c;
    c = cnt[1]; send(0, PRB, 8'h07); check_out(1, c, PRB, 8'h07, "R2");
    c = cnt[0]; send(1, ACK, 8'hAA); check_out(0, c, ACK, 8'hAA, "R5");
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int c;
    int tot;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 5'b0, "R1", out_valid, 0);
    chk(err_drop == 1'b0, "R1", err_drop, 0);

    for (int v = 0; v < 6; v++) begin
      logic [DW-1:0] d;
      int p;
      d = VEC[v][10:3];
      p = int'(VEC[v][2:0]);
      c = cnt[p]; send(0, PRB, d);     check_out(p, c, PRB, d, "R2");
      c = cnt[0]; send(p, ACK, ~d);    check_out(0, c, ACK, ~d, "R5");
      c = cnt[p]; send(0, DAT, 8'hC0 + 8'(v)); check_out(p, c, DAT, 8'hC0 + 8'(v), "R6");
      c = cnt[p]; send(0, REL, 8'h00); check_out(p, c, REL, 8'h00, "R6");
      @(negedge clk);
    end

    // R4 and R7: probe held behind a locked output, released with one drain cycle
    lock_0_to_1();
    @(negedge clk);
    drive(2, PRB, 8'h87);
    for (int n = 0; n < 3; n++) begin
      #1 chk(in_ready[2] == 1'b0, "R4", in_ready[2], 0);
      @(negedge clk);
    end
    drive(0, REL, 8'h00);
    #1 chk(in_ready[0] == 1'b1 && in_ready[2] == 1'b0, "R7", {in_ready[0], in_ready[2]}, 2'b10);
    @(negedge clk);
    in_valid[0] = 1'b0;
    #1 chk(in_ready[2] == 1'b0, "R7", in_ready[2], 0);
    @(negedge clk);
    c = cnt[1];
    #1 chk(in_ready[2] == 1'b1, "R7", in_ready[2], 1);
    @(negedge clk);
    in_valid[2] = 1'b0;
    check_out(1, c, PRB, 8'h87, "R4");
    c = cnt[2]; send(1, ACK, 8'h11); check_out(2, c, ACK, 8'h11, "R5");
    send(2, REL, 8'h00);
    repeat (2) @(negedge clk);

    // R3: two probes for the same output at once
    drive(3, PRB, 8'h17);
    drive(4, PRB, 8'h27);
    c = cnt[1];
    #1 chk(in_ready[3] == 1'b1 && in_ready[4] == 1'b0, "R3", {in_ready[3], in_ready[4]}, 2'b10);
    @(negedge clk);
    in_valid[3] = 1'b0;
    #1 chk(in_ready[4] == 1'b0, "R3", in_ready[4], 0);
    @(negedge clk);
    in_valid[4] = 1'b0;
    chk(cty[1] == PRB && cdat[1] == 8'h17 && cnt[1] == c + 1, "R3", cdat[1], 8'h17);
    send(1, ACK, 8'h22);
    send(3, REL, 8'h00);
    repeat (3) @(negedge clk);

    // R9: backpressure on a locked path
    lock_0_to_1();
    out_ready[1] = 1'b0;
    send(0, DAT, 8'hA5);
    drive(0, DAT, 8'h5A);
    for (int n = 0; n < 3; n++) begin
      #1 chk(out_valid[1] && out_data[DW +: DW] == 8'hA5 && out_type[3:2] == DAT, "R9",
             out_data[DW +: DW], 8'hA5);
      chk(in_ready[0] == 1'b0, "R9", in_ready[0], 0);
      @(negedge clk);
    end
    out_ready[1] = 1'b1;
    #1 chk(in_ready[0] == 1'b1, "R9", in_ready[0], 1);
    @(negedge clk);
    in_valid[0] = 1'b0;
    @(negedge clk); #1;
    chk(cdat[1] == 8'h5A, "R9", cdat[1], 8'h5A);
    send(0, REL, 8'h00);
    repeat (3) @(negedge clk);

    // R8: tokens invalid for the input state are dropped
    #1 chk(err_drop == 1'b0, "R8", err_drop, 0);
    tot = cnt[0] + cnt[1] + cnt[2] + cnt[3] + cnt[4];
    @(negedge clk);
    drive(3, DAT, 8'h99);
    #1 chk(in_ready[3] == 1'b1, "R8", in_ready[3], 1);
    @(negedge clk);
    in_valid[3] = 1'b0;
    #1 chk(err_drop == 1'b1, "R8", err_drop, 1);
    send(2, ACK, 8'h33);
    repeat (3) @(negedge clk);
    #1 chk(cnt[0] + cnt[1] + cnt[2] + cnt[3] + cnt[4] == tot, "R8",
           cnt[0] + cnt[1] + cnt[2] + cnt[3] + cnt[4], tot);
    chk(err_drop == 1'b1, "R8", err_drop, 1);

    finish_up();
  end
endmodule